// File: doc/BRIEF.md
# Multi-channel prescaled PWM controller

This block generates up to four pulse-width-modulated outputs from one shared source clock. Each channel owns one 32-bit control word. The word holds an enable, an override that forces full duty, an 8-bit duty value and a 13-bit prescaler field. A channel first divides the source clock by its prescaler field plus one. It then counts 256 prescaled ticks per output period. The output is high while the tick count is below the duty value.

Software reaches the control words through a plain memory-mapped port: a write strobe, an address and write data, plus a read-data bus that is decoded directly from the address. The port has no handshake, because every access completes in one cycle.

Settings apply at once, with no shadow copy:
- A write to a channel restarts its counters.
- Clearing the enable drops the output on the next cycle, without waiting for the period to end.

Top module: `pwm_ctrl`

## Requirements
- R1: Control word layout: prescaler field in bits [12:0], duty in bits [23:16], full-duty override in bit 24, enable in bit 31. A read returns the last value written to that channel, with every other bit reading as zero.
- R2: After reset every control word reads zero and every output is low.
- R3: With prescaler field D, one output period lasts 256*(D+1) source-clock cycles, so a field of 0 divides by 1.
- R4: With the enable set and the override clear, the output is high for the first duty*(D+1) cycles of each period and low for the rest.
- R5: With the enable and the override both set, the output is high on every cycle, whatever the duty bits hold.
- R6: A write that clears the enable drives the output low from the cycle after the write, even in the middle of a period.
- R7: A write to a channel resets its prescaler and tick counters to zero. The cycle after the write is the first cycle of a new period under the new settings.
- R8: Channel c is at byte address c*16. A write to one channel leaves every other channel's word and waveform unchanged.
- R9: A write to an address whose low four bits are not zero, or whose channel index is NUM_CH or higher, changes nothing. A read from such an address returns zero.
- R10: With the enable set, the override clear and a duty of 0, the output stays low for the whole period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock shared by all channels |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, takes effect on the rising edge |
| bus_addr | input | ADDR_W (8) | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | NUM_CH (4) | One PWM output per channel, high when active |

## Verification
The bound checker checks these on every cycle:
- a disabled channel is low, an overridden channel is high, and an enabled channel with zero duty is low;
- a write clears the addressed channel's counters, and the prescale count never passes its field;
- a write to another channel, or to an unmapped address, leaves a control word untouched.

The exact waveform needs the bench, because it depends on a long history. That covers the high time of duty*(D+1) cycles, the return to high at 256*(D+1) cycles, and the new period that begins the cycle after a mid-period rewrite. The bench also covers read-back masking and the reset values.

// File: rtl/pwm_ctrl_pkg.sv
package pwm_ctrl_pkg;
  localparam int REG_W       = 32;
  localparam int DIV_W       = 13;
  localparam int DUTY_W      = 8;
  localparam int DIV_LSB     = 0;
  localparam int DUTY_LSB    = 16;
  localparam int FULL_BIT    = 24;
  localparam int EN_BIT      = 31;
  localparam int STRIDE_LOG2 = 4;

  typedef struct packed {
    logic              en;
    logic              full;
    logic [DUTY_W-1:0] duty;
    logic [DIV_W-1:0]  div;
  } ch_cfg_t;

  function automatic ch_cfg_t unpack_cfg(input logic [REG_W-1:0] w);
    ch_cfg_t c;
    c.en   = w[EN_BIT];
    c.full = w[FULL_BIT];
    c.duty = w[DUTY_LSB +: DUTY_W];
    c.div  = w[DIV_LSB +: DIV_W];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] pack_cfg(input ch_cfg_t c);
    logic [REG_W-1:0] w;
    w                      = '0;
    w[EN_BIT]              = c.en;
    w[FULL_BIT]            = c.full;
    w[DUTY_LSB +: DUTY_W]  = c.duty;
    w[DIV_LSB +: DIV_W]    = c.div;
    return w;
  endfunction
endpackage

// File: rtl/pwm_ctrl_regs.sv
module pwm_ctrl_regs
  import pwm_ctrl_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [REG_W-1:0]          bus_wdata,
  output logic [REG_W-1:0]          bus_rdata,
  output ch_cfg_t [NUM_CH-1:0]      cfg_q,
  output logic [NUM_CH-1:0]         wr_hit
);
  localparam int IDX_W = ADDR_W - STRIDE_LOG2;

  logic [IDX_W-1:0]  idx;
  logic              off_ok;
  logic [NUM_CH-1:0] sel;

  assign idx    = bus_addr[ADDR_W-1:STRIDE_LOG2];
  assign off_ok = (bus_addr[STRIDE_LOG2-1:0] == '0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_word
    assign sel[c]    = off_ok && (idx == IDX_W'(c));
    assign wr_hit[c] = bus_wr && sel[c];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg_q[c] <= '0;
      else if (wr_hit[c])
        cfg_q[c] <= unpack_cfg(bus_wdata);
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (sel[c])
        bus_rdata = pack_cfg(cfg_q[c]);
    end
  end
endmodule

// File: rtl/pwm_ctrl_chan.sv
module pwm_ctrl_chan
  import pwm_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  ch_cfg_t           cfg,
  output logic [DIV_W-1:0]  pre_q,
  output logic [DUTY_W-1:0] tick_q,
  output logic              pwm_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      tick_q <= '0;
    end else if (restart || !cfg.en) begin
      pre_q  <= '0;
      tick_q <= '0;
    end else if (pre_q == cfg.div) begin
      pre_q  <= '0;
      tick_q <= tick_q + 1'b1;
    end else begin
      pre_q  <= pre_q + 1'b1;
    end
  end

  assign pwm_o = cfg.en && (cfg.full || (tick_q < cfg.duty));
endmodule

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_ctrl_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  ch_cfg_t [NUM_CH-1:0]             ch_cfg;
  logic    [NUM_CH-1:0]             ch_hit;
  logic    [NUM_CH-1:0][DIV_W-1:0]  ch_pre;
  logic    [NUM_CH-1:0][DUTY_W-1:0] ch_tick;

  pwm_ctrl_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cfg_q     (ch_cfg),
    .wr_hit    (ch_hit)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    pwm_ctrl_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (ch_hit[c]),
      .cfg     (ch_cfg[c]),
      .pre_q   (ch_pre[c]),
      .tick_q  (ch_tick[c]),
      .pwm_o   (pwm_out[c])
    );
  end
endmodule

// File: rtl/pwm_ctrl_chk.sv
module pwm_ctrl_chk
  import pwm_ctrl_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             bus_wr,
  input ch_cfg_t [NUM_CH-1:0]             ch_cfg,
  input logic    [NUM_CH-1:0]             ch_hit,
  input logic    [NUM_CH-1:0][DIV_W-1:0]  ch_pre,
  input logic    [NUM_CH-1:0][DUTY_W-1:0] ch_tick,
  input logic    [NUM_CH-1:0]             pwm_out
);
  // R9
  unmapped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && ch_hit == '0) |=> $stable(ch_cfg));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R6
    dis_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_cfg[c].en |-> !pwm_out[c]);

    // R5
    full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_cfg[c].en && ch_cfg[c].full) |-> pwm_out[c]);

    // R10
    zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_cfg[c].en && !ch_cfg[c].full && ch_cfg[c].duty == '0) |-> !pwm_out[c]);

    // R7
    restart_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_hit[c] |=> (ch_pre[c] == '0 && ch_tick[c] == '0));

    // R3
    pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_pre[c] <= ch_cfg[c].div);

    // R8
    other_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !ch_hit[c]) |=> $stable(ch_cfg[c]));
  end
endmodule

bind pwm_ctrl pwm_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_wr  (bus_wr),
  .ch_cfg  (ch_cfg),
  .ch_hit  (ch_hit),
  .ch_pre  (ch_pre),
  .ch_tick (ch_tick),
  .pwm_out (pwm_out)
);

// File: tb/tb_pwm_ctrl.sv
module tb_pwm_ctrl;
  localparam int NCH = 4;
  localparam int AW  = 8;
  localparam logic [31:0] FIELD_MASK = 32'h81FF_1FFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NCH-1:0] pwm_out;

  int  errors = 0;
  int  checks = 0;
  bit  mon_on = 1'b0;
  bit  done = 1'b0;

  logic [31:0] m_reg [NCH];
  int          m_n   [NCH];

  always #4 clk = ~clk;

  pwm_ctrl #(.NUM_CH(NCH), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  function automatic int map_ch(input logic [AW-1:0] a);
    if (a[3:0] != 4'd0) return -1;
    if (int'(a[7:4]) >= NCH) return -1;
    return int'(a[7:4]);
  endfunction

  function automatic logic exp_out(input logic [31:0] r, input int n);
    int per;
    int ph;
    if (!r[31]) return 1'b0;
    if (r[24]) return 1'b1;
    per = int'(r[12:0]) + 1;
    ph  = n % (256 * per);
    return ph < int'(r[23:16]) * per;
  endfunction

  function automatic string tag_of(input logic [31:0] r);
    if (!r[31]) return "R6 disabled";
    if (r[24]) return "R5 full duty";
    if (r[23:16] == 8'd0) return "R10 zero duty";
    return "R3/R4 waveform";
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_reg[c] = '0;
        m_n[c]   = 0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (bus_wr && map_ch(bus_addr) == c) begin
          m_reg[c] = bus_wdata & FIELD_MASK;
          m_n[c]   = 0;
        end else begin
          m_n[c]++;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (mon_on) begin
      for (int c = 0; c < NCH; c++) begin
        logic e;
        e = exp_out(m_reg[c], m_n[c]);
        check(pwm_out[c] === e, tag_of(m_reg[c]), 32'(pwm_out[c]), 32'(e));
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(bus_rdata === exp, req, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int hi;
    void'($urandom(32'd7341));
    idle(3);
    rst_n = 1'b1;
    // R2: reset values
    for (int c = 0; c < NCH; c++) begin
      rd_chk(AW'(c * 16), 32'h0, "R2 reset word");
      check(pwm_out[c] === 1'b0, "R2 reset output", 32'(pwm_out[c]), 32'h0);
    end
    mon_on = 1'b1;

    // R1: field masking on read-back
    wr(8'h00, 32'hFFFF_FFFF);
    rd_chk(8'h00, 32'h81FF_1FFF, "R1 read-back mask");
    // R5: override with duty 0 still high
    wr(8'h00, 32'h8100_0001);
    idle(600);
    check(pwm_out[0] === 1'b1, "R5 override", 32'(pwm_out[0]), 32'h1);
    // R10: zero duty
    wr(8'h10, 32'h8000_0000);
    idle(300);
    check(pwm_out[1] === 1'b0, "R10 zero duty", 32'(pwm_out[1]), 32'h0);

    // R3/R4: duty 64, divisor 3 -> 192 high cycles in a 768-cycle period
    wr(8'h20, 32'h8040_0002);
    hi = 0;
    for (int i = 0; i < 768; i++) begin
      if (i == 767) check(pwm_out[2] === 1'b0, "R3 end of period", 32'(pwm_out[2]), 32'h0);
      if (pwm_out[2]) hi++;
      @(negedge clk);
    end
    check(hi == 192, "R4 high count", 32'(hi), 32'd192);
    check(pwm_out[2] === 1'b1, "R3 next period start", 32'(pwm_out[2]), 32'h1);

    // R7: mid-period rewrite while low restarts at once
    idle(400);
    check(pwm_out[2] === 1'b0, "R7 precondition low", 32'(pwm_out[2]), 32'h0);
    wr(8'h20, 32'h80C8_0002);
    check(pwm_out[2] === 1'b1, "R7 restart high", 32'(pwm_out[2]), 32'h1);
    idle(5);

    // R6: disable mid-period while high
    wr(8'h20, 32'h00C8_0002);
    check(pwm_out[2] === 1'b0, "R6 abrupt disable", 32'(pwm_out[2]), 32'h0);
    rd_chk(8'h20, 32'h00C8_0002, "R6 enable cleared");

    // R8: other channels untouched
    wr(8'h30, 32'h8010_0000);
    rd_chk(8'h00, 32'h8100_0001, "R8 ch0 unchanged");
    rd_chk(8'h10, 32'h8000_0000, "R8 ch1 unchanged");
    rd_chk(8'h30, 32'h8010_0000, "R8 ch3 word");

    // R9: unmapped offsets
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h38, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    rd_chk(8'h04, 32'h0, "R9 read offset 4");
    rd_chk(8'h40, 32'h0, "R9 read index 4");
    rd_chk(8'h00, 32'h8100_0001, "R9 ch0 kept");
    rd_chk(8'h30, 32'h8010_0000, "R9 ch3 kept");
    idle(300);

    // Random phase
    for (int k = 0; k < 70; k++) begin
      int          ch;
      logic [31:0] d;
      logic [7:0]  duty;
      ch = $urandom_range(0, NCH - 1);
      case ($urandom_range(0, 3))
        0:       duty = 8'd0;
        1:       duty = 8'd255;
        default: duty = 8'($urandom_range(1, 254));
      endcase
      d = ($urandom & ~FIELD_MASK)
        | (($urandom_range(0, 7) != 0) ? 32'h8000_0000 : 32'h0)
        | (($urandom_range(0, 7) == 0) ? 32'h0100_0000 : 32'h0)
        | (32'(duty) << 16)
        | 32'($urandom_range(0, 3));
      if ($urandom_range(0, 9) == 0) begin
        wr(AW'(ch * 16 + 8), d);
        rd_chk(AW'(ch * 16 + 8), 32'h0, "R9 random unmapped");
      end else begin
        wr(AW'(ch * 16), d);
        rd_chk(AW'(ch * 16), d & FIELD_MASK, "R1 random read-back");
      end
      idle($urandom_range(50, 1200));
    end

    mon_on = 1'b0;
    done   = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule